// File: doc/BRIEF.md
# NAND Flash Host Interface

This block sits between a byte-wide host register bus and an external NAND flash device. It owns two address regions. The first is a fixed configuration page, which holds a window-enable flag and a 32-bit relocatable base address. The second is an operating window, which answers only while it is enabled and only at the page the base register names. Through the window the host reaches a data port, a pin-control (mode) register, a constant status byte, and a pair of interrupt status and mask registers.

Writes to the mode register drive the flash control pins directly. Writes and reads on the data port move one byte across the flash I/O bus. A two-bit field of the mode register is decoded into strobes for an external ECC engine. An interrupt line is raised toward the chip-level interrupt collector. Address page 0 is left to the neighbouring system register block: this block ignores writes there and returns 0 on reads there. Every bus read returns its byte one cycle after the read request.

Top module: `nand_host_if`

## Requirements
- R1: After reset the window is disabled, the base register is 0, the mode, interrupt status and interrupt mask registers are 0, `nand_ce_n` is 1, `irq` is 0 and every strobe output is 0.
- R2: In the configuration page (address bits 15:8 equal to 0x01), a write to offset 0x04 sets the window enable to data bit 1. A read of offset 0x04 returns 0x02 while the window is enabled and 0x00 otherwise.
- R3: The base register occupies configuration offsets 0x10 to 0x13. Offset 0x10+k holds byte lane k (bits 8k+7:8k), and each lane is written and read on its own. Other configuration offsets read 0.
- R4: An address reaches the window only when the window is enabled, its page (bits 15:8) is neither 0 nor 1, and the zero-extended value {bits 15:8, 0x00} equals the base register. Pages 0 and 1 take precedence over any base value. A write that misses the window changes no window state and produces no strobe. A read that misses the window and the configuration page returns 0.
- R5: A window write to any offset 0x00 to 0x03 raises `nand_we` for exactly the next cycle, with `nand_dout` carrying the written byte. `nand_dout` holds that byte until the next data write. The write also sets interrupt status bit 0.
- R6: A window read of any offset 0x00 to 0x03 raises `nand_re` in the same cycle. The `nand_din` value present in that cycle appears on `bus_rdata` in the next cycle.
- R7: Window offset 0x04 is the mode register, and it reads back as written. Starting the cycle after a write, `nand_cle` follows bit 0, `nand_ale` follows bit 1, `nand_ce_n` follows the inverse of bit 4, and `nand_wp` follows bit 7.
- R8: Mode bits 6:5 command the ECC engine, and the strobe comes one cycle after the mode write. Code 01 pulses `ecc_clear` and holds `ecc_active` high while the field stays 01. Code 11 pulses `ecc_clear`. Code 10 pulses `ecc_readout`. Code 00 produces no strobe.
- R9: Window offset 0x05 always reads 0x14. Window offsets 0x08 to 0xFF read 0.
- R10: Window offset 0x06 (interrupt status) and offset 0x07 (interrupt mask) are each replaced whole by a write and read back their value.
- R11: `irq` is 1 exactly when mask bit 7 is 1 and the bitwise AND of mask and status is nonzero. It reflects a register write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write request, one cycle per byte |
| bus_rd | input | 1 | Read request, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd`, otherwise 0 |
| nand_din | input | 8 | Byte driven by the flash during a read strobe |
| nand_dout | output | 8 | Byte presented to the flash |
| nand_we | output | 1 | One-cycle write strobe |
| nand_re | output | 1 | One-cycle read strobe |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_wp | output | 1 | Write protect |
| ecc_clear | output | 1 | ECC reset strobe |
| ecc_readout | output | 1 | ECC read-out strobe |
| ecc_active | output | 1 | ECC accumulation enabled |
| irq | output | 1 | Interrupt request |

## Verification
Address decode is tried with the window enabled and disabled, with a matching base and a mismatched base, with a base whose low byte is nonzero, and with a base that points into the configuration page. Together these show whether enable, base match and page priority are each honoured. Mode writes sweep every ECC code and several pin patterns, which separates the CE inversion and each strobe from the others. Interrupt sequences vary the mask global bit and the overlap of mask and status one at a time, so an output that ignores either condition is exposed.

// File: rtl/nhi_pkg.sv
package nhi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SYS  = 2'd1,
    RGN_CFG  = 2'd2,
    RGN_WIN  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ECC_IDLE  = 2'b00,
    ECC_ARM   = 2'b01,
    ECC_DUMP  = 2'b10,
    ECC_CLEAR = 2'b11
  } ecc_cmd_e;

  // configuration page offsets
  localparam logic [7:0] CFG_CMD_OFS  = 8'h04;
  localparam logic [7:0] CFG_BASE_OFS = 8'h10;
  localparam int         CFG_EN_BIT   = 1;

  // window offsets
  localparam logic [7:0] WIN_MODE_OFS = 8'h04;
  localparam logic [7:0] WIN_STAT_OFS = 8'h05;
  localparam logic [7:0] WIN_ISR_OFS  = 8'h06;
  localparam logic [7:0] WIN_IMR_OFS  = 8'h07;
  localparam logic [7:0] STATUS_VALUE = 8'h14;

  // mode register bit positions
  localparam int MB_CLE    = 0;
  localparam int MB_ALE    = 1;
  localparam int MB_CE     = 4;
  localparam int MB_ECC_LO = 5;
  localparam int MB_WP     = 7;
  localparam int IMR_GLOBAL = 7;
endpackage

// File: rtl/nhi_decode.sv
module nhi_decode
  import nhi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 32
) (
  input  logic [ADDR_W-9:0] page,
  input  logic [BASE_W-1:0] base,
  input  logic              win_en,
  output region_e           region
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [BASE_W-1:0] win_addr;

  always_comb begin
    win_addr = '0;
    win_addr[ADDR_W-1:8] = page;
  end

  always_comb begin
    if (page == PAGE_W'(0)) begin
      region = RGN_SYS;
    end else if (page == PAGE_W'(1)) begin
      region = RGN_CFG;
    end else if (win_en && (win_addr == base)) begin
      region = RGN_WIN;
    end else begin
      region = RGN_NONE;
    end
  end
endmodule

// File: rtl/nhi_cfg_regs.sv
module nhi_cfg_regs
  import nhi_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        ofs,
  input  logic [7:0]        wdata,
  output logic              win_en,
  output logic [BASE_W-1:0] base,
  output logic [7:0]        rd_data
);
  localparam int LANES = BASE_W / BYTE_W;

  logic                   en_q, en_d;
  logic [LANES-1:0][7:0]  base_q, base_d;
  logic [7:0]             lane_idx;

  always_comb begin
    en_d = en_q;
    if (wr_en && ofs == CFG_CMD_OFS) begin
      en_d = wdata[CFG_EN_BIT];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      base_d[g] = base_q[g];
      if (wr_en && ofs == CFG_BASE_OFS + 8'(g)) begin
        base_d[g] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else begin
      en_q   <= en_d;
      base_q <= base_d;
    end
  end

  assign lane_idx = ofs - CFG_BASE_OFS;

  always_comb begin
    rd_data = '0;
    if (ofs == CFG_CMD_OFS) begin
      rd_data[CFG_EN_BIT] = en_q;
    end else if (ofs >= CFG_BASE_OFS && lane_idx < 8'(LANES)) begin
      rd_data = base_q[lane_idx[$clog2(LANES)-1:0]];
    end
  end

  assign win_en = en_q;
  assign base   = base_q;
endmodule

// File: rtl/nhi_win_regs.sv
module nhi_win_regs
  import nhi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] ofs,
  input  logic [7:0] wdata,
  input  logic [7:0] nand_din,
  output logic [7:0] rd_data,
  output logic [7:0] nand_dout,
  output logic       nand_we,
  output logic       nand_re,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_ce_n,
  output logic       nand_wp,
  output logic       ecc_clear,
  output logic       ecc_readout,
  output logic       ecc_active,
  output logic       irq
);
  logic       data_ofs;
  logic [7:0] mode_q, mode_d;
  logic [7:0] isr_q, isr_d;
  logic [7:0] imr_q, imr_d;
  logic [7:0] dout_q, dout_d;
  logic       we_q, we_d;
  logic       clr_q, clr_d;
  logic       rdo_q, rdo_d;
  ecc_cmd_e   cmd_new;

  assign data_ofs = (ofs[7:2] == 6'd0);
  assign cmd_new  = ecc_cmd_e'(wdata[MB_ECC_LO +: 2]);

  always_comb begin
    mode_d = mode_q;
    isr_d  = isr_q;
    imr_d  = imr_q;
    dout_d = dout_q;
    we_d   = 1'b0;
    clr_d  = 1'b0;
    rdo_d  = 1'b0;
    if (wr_en) begin
      if (data_ofs) begin
        dout_d   = wdata;
        we_d     = 1'b1;
        isr_d[0] = 1'b1;
      end else begin
        unique case (ofs)
          WIN_MODE_OFS: begin
            mode_d = wdata;
            clr_d  = (cmd_new == ECC_ARM) || (cmd_new == ECC_CLEAR);
            rdo_d  = (cmd_new == ECC_DUMP);
          end
          WIN_ISR_OFS: isr_d = wdata;
          WIN_IMR_OFS: imr_d = wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      dout_q <= '0;
      we_q   <= 1'b0;
      clr_q  <= 1'b0;
      rdo_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      isr_q  <= isr_d;
      imr_q  <= imr_d;
      dout_q <= dout_d;
      we_q   <= we_d;
      clr_q  <= clr_d;
      rdo_q  <= rdo_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (data_ofs) begin
      rd_data = nand_din;
    end else begin
      unique case (ofs)
        WIN_MODE_OFS: rd_data = mode_q;
        WIN_STAT_OFS: rd_data = STATUS_VALUE;
        WIN_ISR_OFS:  rd_data = isr_q;
        WIN_IMR_OFS:  rd_data = imr_q;
        default:      rd_data = '0;
      endcase
    end
  end

  assign nand_re     = rd_en && data_ofs;
  assign nand_we     = we_q;
  assign nand_dout   = dout_q;
  assign nand_cle    = mode_q[MB_CLE];
  assign nand_ale    = mode_q[MB_ALE];
  assign nand_ce_n   = ~mode_q[MB_CE];
  assign nand_wp     = mode_q[MB_WP];
  assign ecc_clear   = clr_q;
  assign ecc_readout = rdo_q;
  assign ecc_active  = (ecc_cmd_e'(mode_q[MB_ECC_LO +: 2]) == ECC_ARM);
  assign irq         = imr_q[IMR_GLOBAL] && |(imr_q & isr_q);
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nhi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        nand_din,
  output logic [7:0]        nand_dout,
  output logic              nand_we,
  output logic              nand_re,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_wp,
  output logic              ecc_clear,
  output logic              ecc_readout,
  output logic              ecc_active,
  output logic              irq
);
  logic              rst_meta, rst_sync_n;
  region_e           region;
  logic              win_en;
  logic [BASE_W-1:0] base;
  logic [7:0]        cfg_rd, win_rd;
  logic [7:0]        rdata_q, rdata_d;
  logic              cfg_wr, win_wr, win_rdreq;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  nhi_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_decode (
    .page   (bus_addr[ADDR_W-1:8]),
    .base   (base),
    .win_en (win_en),
    .region (region)
  );

  assign cfg_wr    = bus_wr && (region == RGN_CFG);
  assign win_wr    = bus_wr && (region == RGN_WIN);
  assign win_rdreq = bus_rd && (region == RGN_WIN);

  nhi_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr),
    .ofs     (bus_addr[7:0]),
    .wdata   (bus_wdata),
    .win_en  (win_en),
    .base    (base),
    .rd_data (cfg_rd)
  );

  nhi_win_regs u_win (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (win_wr),
    .rd_en       (win_rdreq),
    .ofs         (bus_addr[7:0]),
    .wdata       (bus_wdata),
    .nand_din    (nand_din),
    .rd_data     (win_rd),
    .nand_dout   (nand_dout),
    .nand_we     (nand_we),
    .nand_re     (nand_re),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_ce_n   (nand_ce_n),
    .nand_wp     (nand_wp),
    .ecc_clear   (ecc_clear),
    .ecc_readout (ecc_readout),
    .ecc_active  (ecc_active),
    .irq         (irq)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      unique case (region)
        RGN_CFG: rdata_d = cfg_rd;
        RGN_WIN: rdata_d = win_rd;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/nhi_checker.sv
module nhi_checker
  import nhi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        nand_din,
  input logic [7:0]        nand_dout,
  input logic              nand_we,
  input logic              nand_re,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_ce_n,
  input logic              nand_wp,
  input logic              ecc_clear,
  input logic              ecc_readout,
  input logic              irq,
  input region_e           region,
  input logic              win_en
);
  logic win_w, win_r;
  assign win_w = bus_wr && (region == RGN_WIN);
  assign win_r = bus_rd && (region == RGN_WIN);

  assert_cfg_enable_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && region == RGN_CFG && bus_addr[7:0] == CFG_CMD_OFS) |=> (win_en == $past(bus_wdata[CFG_EN_BIT])));

  assert_we_source_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nand_we |-> $past(win_w));

  assert_sys_page_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr[ADDR_W-1:8] == '0) |=> (bus_rdata == 8'h00));

  assert_data_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_w && bus_addr[7:2] == 6'd0) |=> (nand_we && nand_dout == $past(bus_wdata)));

  assert_re_window_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nand_re |-> win_r);

  assert_read_return_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nand_re |=> (bus_rdata == $past(nand_din)));

  assert_mode_pins_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_w && bus_addr[7:0] == WIN_MODE_OFS) |=>
      (nand_cle == $past(bus_wdata[MB_CLE]) && nand_ale == $past(bus_wdata[MB_ALE]) &&
       nand_ce_n == !$past(bus_wdata[MB_CE]) && nand_wp == $past(bus_wdata[MB_WP])));

  assert_ecc_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ecc_clear && ecc_readout));

  assert_status_const_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_r && bus_addr[7:0] == WIN_STAT_OFS) |=> (bus_rdata == STATUS_VALUE));

  assert_irq_global_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_w && bus_addr[7:0] == WIN_IMR_OFS && !bus_wdata[IMR_GLOBAL]) |=> !irq);
endmodule

bind nand_host_if nhi_checker #(.ADDR_W(ADDR_W)) u_nhi_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .nand_din    (nand_din),
  .nand_dout   (nand_dout),
  .nand_we     (nand_we),
  .nand_re     (nand_re),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_ce_n   (nand_ce_n),
  .nand_wp     (nand_wp),
  .ecc_clear   (ecc_clear),
  .ecc_readout (ecc_readout),
  .irq         (irq),
  .region      (region),
  .win_en      (win_en)
);

// File: tb/test_nand_host_if.sv
module test_nand_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  nand_din = '0;
  logic [7:0]  bus_rdata, nand_dout;
  logic        nand_we, nand_re, nand_cle, nand_ale, nand_ce_n, nand_wp;
  logic        ecc_clear, ecc_readout, ecc_active, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;   // 50 MHz

  nand_host_if i_nand_host_if (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_din(nand_din), .nand_dout(nand_dout),
    .nand_we(nand_we), .nand_re(nand_re), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_ce_n(nand_ce_n), .nand_wp(nand_wp), .ecc_clear(ecc_clear),
    .ecc_readout(ecc_readout), .ecc_active(ecc_active), .irq(irq)
  );

  // behavioural reference state
  bit       m_en;
  bit [31:0] m_base;
  bit [7:0] m_mode, m_isr, m_imr, m_dout, m_rdata;
  bit       m_we, m_clr, m_rdo;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_hit(input logic [15:0] a);
    return m_en && (a[15:8] > 8'd1) && (m_base == {16'h0, a[15:8], 8'h00});
  endfunction

  function automatic bit [7:0] m_read(input logic [15:0] a);
    if (a[15:8] == 8'd1) begin
      if (a[7:0] == 8'h04) return {6'd0, m_en, 1'b0};
      if (a[7:0] >= 8'h10 && a[7:0] <= 8'h13) return m_base[8*(a[7:0]-8'h10) +: 8];
      return 8'h00;
    end
    if (!m_hit(a)) return 8'h00;
    if (a[7:0] < 8'h04) return nand_din;
    case (a[7:0])
      8'h04: return m_mode;
      8'h05: return 8'h14;
      8'h06: return m_isr;
      8'h07: return m_imr;
      default: return 8'h00;
    endcase
  endfunction

  // model step on each rising edge, comparison shortly after
  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      m_en = 0; m_base = 0; m_mode = 0; m_isr = 0; m_imr = 0; m_dout = 0;
      m_rdata = 0; m_we = 0; m_clr = 0; m_rdo = 0;
    end else begin
      hit = m_hit(bus_addr);
      m_rdata = bus_rd ? m_read(bus_addr) : 8'h00;
      m_we = 0; m_clr = 0; m_rdo = 0;
      if (bus_wr) begin
        if (bus_addr[15:8] == 8'd1) begin
          if (bus_addr[7:0] == 8'h04) m_en = bus_wdata[1];
          if (bus_addr[7:0] >= 8'h10 && bus_addr[7:0] <= 8'h13)
            m_base[8*(bus_addr[7:0]-8'h10) +: 8] = bus_wdata;
        end else if (hit) begin
          if (bus_addr[7:0] < 8'h04) begin
            m_we = 1; m_dout = bus_wdata; m_isr[0] = 1'b1;
          end else if (bus_addr[7:0] == 8'h04) begin
            m_mode = bus_wdata;
            m_clr = (bus_wdata[6:5] == 2'b01) || (bus_wdata[6:5] == 2'b11);
            m_rdo = (bus_wdata[6:5] == 2'b10);
          end else if (bus_addr[7:0] == 8'h06) m_isr = bus_wdata;
          else if (bus_addr[7:0] == 8'h07) m_imr = bus_wdata;
        end
      end
    end
    #5;
    if (rst_n) begin
      chk(cur_req, "bus_rdata", bus_rdata, m_rdata);
      chk("R7", "nand_cle", nand_cle, m_mode[0]);
      chk("R7", "nand_ale", nand_ale, m_mode[1]);
      chk("R7", "nand_ce_n", nand_ce_n, !m_mode[4]);
      chk("R7", "nand_wp", nand_wp, m_mode[7]);
      chk("R5", "nand_we", nand_we, m_we);
      chk("R5", "nand_dout", nand_dout, m_dout);
      chk("R6", "nand_re", nand_re, bus_rd && m_hit(bus_addr) && bus_addr[7:2] == 0);
      chk("R8", "ecc_clear", ecc_clear, m_clr);
      chk("R8", "ecc_readout", ecc_readout, m_rdo);
      chk("R8", "ecc_active", ecc_active, m_mode[6:5] == 2'b01);
      chk("R11", "irq", irq, m_imr[7] && ((m_imr & m_isr) != 0));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    cur_req = req;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, "read data", bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values at the ports
    chk("R1", "nand_ce_n reset", nand_ce_n, 1);
    chk("R1", "irq reset", irq, 0);
    chk("R1", "strobes reset", {nand_we, ecc_clear, ecc_readout, ecc_active}, 0);
    rd("R1", 16'h0110, 8'h00);
    rd("R2", 16'h0104, 8'h00);

    // R2 enable bit
    wr(16'h0104, 8'h02);
    rd("R2", 16'h0104, 8'h02);
    wr(16'h0104, 8'hFD);
    rd("R2", 16'h0104, 8'h00);
    wr(16'h0104, 8'h02);

    // R3 base lanes
    wr(16'h0111, 8'h30);
    wr(16'h0113, 8'h00);
    rd("R3", 16'h0111, 8'h30);
    rd("R3", 16'h0110, 8'h00);
    rd("R3", 16'h0114, 8'h00);

    // R7 pins
    cur_req = "R7";
    wr(16'h3004, 8'h93);
    rd("R7", 16'h3004, 8'h93);
    wr(16'h3004, 8'h00);

    // R5 data writes and status bit
    wr(16'h3000, 8'hA5);
    wr(16'h3003, 8'h5A);
    rd("R5", 16'h3006, 8'h01);

    // R6 data read
    nand_din = 8'hC3;
    @(negedge clk);
    bus_addr = 16'h3002; bus_rd = 1'b1;
    #1 chk("R6", "nand_re same cycle", nand_re, 1);
    @(negedge clk);
    bus_rd = 1'b0;
    nand_din = 8'h11;
    chk("R6", "flash byte returned", bus_rdata, 8'hC3);

    // R9 status and undecoded
    rd("R9", 16'h3005, 8'h14);
    rd("R9", 16'h3008, 8'h00);
    rd("R9", 16'h30FF, 8'h00);

    // R8 ECC codes
    wr(16'h3004, 8'h20);
    wr(16'h3004, 8'h40);
    wr(16'h3004, 8'h60);
    wr(16'h3004, 8'h00);
    chk("R8", "ecc_active after 00", ecc_active, 0);

    // R10 / R11 interrupts
    wr(16'h3006, 8'h01);
    wr(16'h3007, 8'h01);
    chk("R11", "irq without global", irq, 0);
    wr(16'h3007, 8'h81);
    chk("R11", "irq global+match", irq, 1);
    wr(16'h3006, 8'h02);
    chk("R11", "irq no overlap", irq, 0);
    wr(16'h3007, 8'h82);
    chk("R11", "irq overlap bit1", irq, 1);
    rd("R10", 16'h3007, 8'h82);
    rd("R10", 16'h3006, 8'h02);
    wr(16'h3007, 8'h80);
    wr(16'h3006, 8'h00);

    // R4 decode gating
    wr(16'h0104, 8'h00);
    wr(16'h3004, 8'hFF);
    wr(16'h3000, 8'h77);
    chk("R4", "pins untouched when disabled", nand_cle, 0);
    rd("R4", 16'h3007, 8'h00);
    wr(16'h0104, 8'h02);
    wr(16'h4004, 8'hFF);
    rd("R4", 16'h4005, 8'h00);
    wr(16'h0110, 8'h10);
    wr(16'h3004, 8'h13);
    rd("R4", 16'h3005, 8'h00);
    wr(16'h0110, 8'h00);
    wr(16'h0111, 8'h01);
    rd("R4", 16'h0105, 8'h00);
    wr(16'h0004, 8'hFF);
    rd("R4", 16'h0005, 8'h00);
    wr(16'h0111, 8'h30);
    rd("R4", 16'h3005, 8'h14);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule